// File: doc/BRIEF.md
# External Interrupt Request Capture

This block turns one active-low external interrupt line into a request flag for an interrupt controller. The asynchronous line first passes through a short synchronizer chain. It is then sampled only on clock cycles where the machine-cycle strobe is asserted. The strobe marks one clock in every machine cycle, so short glitches between strobes are never seen.

A sense-mode input selects how the request is formed. In level mode, the request follows the inverse of the most recent sample, and nothing but the line itself can remove it. In edge mode, a high sample followed by a low sample on the next strobe latches the request. The latched request stays set until the controller acknowledges the vector or software writes a clear. When a new edge lands in the same cycle as a clear, the new edge takes precedence.

Top module: `ext_irq_capture`

## Requirements
- R1: While reset is asserted and after it is released, `req_o` is 0 as long as the line stays high. The held sample resets to high, so the first strobe after reset cannot report a false edge from an idle line.
- R2: With `edge_mode_i` = 0 (level sense), `req_o` equals the inverse of the line value taken at the most recent strobe. It updates on the clock edge that carries the strobe.
- R3: With `edge_mode_i` = 0, `ack_i` and `sw_clr_i` have no effect on `req_o`.
- R4: With `edge_mode_i` = 1, a strobe that takes a low sample when the previous strobe took a high one sets `req_o` on that clock edge.
- R5: With `edge_mode_i` = 1, the sample pairs low→low, high→high and low→high never set `req_o`.
- R6: With `edge_mode_i` = 1, `ack_i` clears the latched request on the next clock edge.
- R7: With `edge_mode_i` = 1, `sw_clr_i` clears the latched request on the next clock edge.
- R8: With `edge_mode_i` = 1, when an edge is detected in the same cycle as `ack_i` or `sw_clr_i`, `req_o` ends up set.
- R9: The sample changes only on strobe cycles. Line changes between strobes do not alter `req_o`.
- R10: A line change reaches the sampler after SYNC_STAGES clock edges. A strobe on the SYNC_STAGES-th edge after the change still takes the old value; a strobe one edge later takes the new value.
- R11: While `edge_mode_i` = 0, the latched edge request is held clear. After a switch to edge mode, `req_o` stays 0 until a new edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt line, active low, asynchronous |
| mcyc_stb_i | input | 1 | One-clock strobe, once per machine cycle |
| edge_mode_i | input | 1 | 0 = level sense, 1 = falling-edge sense |
| ack_i | input | 1 | Controller acknowledge (vector taken) |
| sw_clr_i | input | 1 | Software clear of the latched request |
| req_o | output | 1 | Interrupt request to the controller |

## Verification
The hardest case to reach is an edge detection that falls on exactly the same clock as an acknowledge or software clear. To reach it, the line must already have been sampled high on an earlier strobe. The new low level must also have passed fully through the synchronizer before the strobe arrives. The bench sweeps every combination of the prior sample, the current line, strobe, acknowledge and clear in both modes. Before each line change it waits out the synchronizer latency, so the strobe, the clear and the edge coincide by construction. A separate sequence moves the strobe one clock earlier and one clock later around the synchronizer latency, to pin down the R10 boundary.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q[i] <= RESET_VAL;
        end else begin
          chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic stb_i,
  output logic samp_o,
  output logic fall_o
);
  logic samp_q;

  // held sample resets high: an idle line never reads as a fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b1;
    end else if (stb_i) begin
      samp_q <= line_i;
    end
  end

  assign fall_o = stb_i & samp_q & ~line_i;
  assign samp_o = samp_q;
endmodule

// File: rtl/irq_flag.sv
module irq_flag
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e sense_i,
  input  logic   fall_i,
  input  logic   samp_i,
  input  logic   ack_i,
  input  logic   clr_i,
  output logic   edge_q_o,
  output logic   req_o
);
  logic edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= 1'b0;
    end else if (sense_i == SENSE_LEVEL) begin
      edge_q <= 1'b0;
    end else if (fall_i) begin
      edge_q <= 1'b1; // new edge beats a clear
    end else if (ack_i || clr_i) begin
      edge_q <= 1'b0;
    end
  end

  assign edge_q_o = edge_q;
  assign req_o    = (sense_i == SENSE_EDGE) ? edge_q : ~samp_i;
endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic mcyc_stb_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  input  logic sw_clr_i,
  output logic req_o
);
  logic   pin_s;
  logic   samp_q;
  logic   fall;
  logic   edge_q;
  sense_e sense;

  assign sense = sense_e'(edge_mode_i);

  irq_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  irq_sampler u_samp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (pin_s),
    .stb_i  (mcyc_stb_i),
    .samp_o (samp_q),
    .fall_o (fall)
  );

  irq_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sense_i  (sense),
    .fall_i   (fall),
    .samp_i   (samp_q),
    .ack_i    (ack_i),
    .clr_i    (sw_clr_i),
    .edge_q_o (edge_q),
    .req_o    (req_o)
  );
endmodule

// File: rtl/ext_irq_capture_chk.sv
module ext_irq_capture_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_s,
  input logic samp_q,
  input logic edge_q,
  input logic mcyc_stb_i,
  input logic edge_mode_i,
  input logic ack_i,
  input logic sw_clr_i,
  input logic req_o
);
  assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && mcyc_stb_i && samp_q && !pin_s) |=> edge_q);

  // R8: the set must survive a simultaneous clear
  assert_edge_beats_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && mcyc_stb_i && samp_q && !pin_s && (ack_i || sw_clr_i)) |=> edge_q);

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(mcyc_stb_i && samp_q && !pin_s)) |=> !edge_q);

  assert_no_set_off_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcyc_stb_i && !edge_q) |=> !edge_q);

  assert_level_mirror_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && mcyc_stb_i) ##1 !edge_mode_i |-> (req_o == !$past(pin_s)));

  assert_level_ignores_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !mcyc_stb_i) ##1 !edge_mode_i |-> $stable(req_o));

  assert_level_drops_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> !edge_q);
endmodule

bind ext_irq_capture ext_irq_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_s       (pin_s),
  .samp_q      (samp_q),
  .edge_q      (edge_q),
  .mcyc_stb_i  (mcyc_stb_i),
  .edge_mode_i (edge_mode_i),
  .ack_i       (ack_i),
  .sw_clr_i    (sw_clr_i),
  .req_o       (req_o)
);

// File: tb/ext_irq_capture_tb.sv
module ext_irq_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pin_i = 1'b1;
  logic mcyc_stb_i = 1'b0;
  logic edge_mode_i = 1'b0;
  logic ack_i = 1'b0;
  logic sw_clr_i = 1'b0;
  logic req_o;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_samp = 1'b1;
  logic exp_eflag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ext_irq_capture #(.SYNC_STAGES(SYNC)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_i       (pin_i),
    .mcyc_stb_i  (mcyc_stb_i),
    .edge_mode_i (edge_mode_i),
    .ack_i       (ack_i),
    .sw_clr_i    (sw_clr_i),
    .req_o       (req_o)
  );

  function automatic logic exp_req();
    return edge_mode_i ? exp_eflag : ~exp_samp;
  endfunction

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (req_o !== exp) begin
      n_fail++;
      $display("FAIL %s: req_o=%b expected=%b t=%0t", tag, req_o, exp, $time);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk_i);
    edge_mode_i = m;
    @(negedge clk_i);
    if (!m) exp_eflag = 1'b0;
  endtask

  // change line, wait out synchronizer, then one cycle with stb/ack/clr
  task automatic cyc(input logic pin, input logic stb, input logic ack,
                     input logic clr, input string tag);
    logic fall;
    @(negedge clk_i);
    pin_i = pin;
    repeat (SYNC) @(negedge clk_i);
    check({tag, "_pre"}, exp_req());
    mcyc_stb_i = stb;
    ack_i = ack;
    sw_clr_i = clr;
    @(negedge clk_i);
    mcyc_stb_i = 1'b0;
    ack_i = 1'b0;
    sw_clr_i = 1'b0;
    fall = edge_mode_i & stb & exp_samp & ~pin;
    if (!edge_mode_i)     exp_eflag = 1'b0;
    else if (fall)        exp_eflag = 1'b1;
    else if (ack || clr)  exp_eflag = 1'b0;
    if (stb) exp_samp = pin;
    check(tag, exp_req());
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0);
    rst_ni = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R1");
    set_mode(1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R1");

    // sweep both modes, prior sample, current line, stb, ack, clr
    for (int m = 0; m < 2; m++) begin
      for (int p0 = 0; p0 < 2; p0++)
        for (int p1 = 0; p1 < 2; p1++)
          for (int s = 0; s < 2; s++)
            for (int a = 0; a < 2; a++)
              for (int c = 0; c < 2; c++) begin
                string tag;
                logic fall;
                set_mode(logic'(m));
                // prime a latched request (edge mode) before the case
                cyc(1'b1, 1'b1, 1'b0, 1'b0, "R5");
                cyc(1'b0, 1'b1, 1'b0, 1'b0, m ? "R4" : "R2");
                cyc(logic'(p0), 1'b1, 1'b0, 1'b0, m ? "R5" : "R2");
                fall = logic'(m) & logic'(s) & logic'(p0) & ~logic'(p1);
                if (m == 0)          tag = (a || c) ? "R3" : (s ? "R2" : "R9");
                else if (fall && (a || c)) tag = "R8";
                else if (fall)       tag = "R4";
                else if (a)          tag = "R6";
                else if (c)          tag = "R7";
                else if (!s)         tag = "R9";
                else                 tag = "R5";
                cyc(logic'(p1), logic'(s), logic'(a), logic'(c), tag);
              end
    end

    // R11: switch to level then back; stale edge flag must be gone
    set_mode(1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R11");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R11");
    check("R11_set", 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R11");
    set_mode(1'b0);
    check("R11_lvl", 1'b0);
    set_mode(1'b1);
    check("R11_edge", 1'b0);

    // R10: strobe on edge SYNC after change takes old value, SYNC+1 the new
    @(negedge clk_i);
    pin_i = 1'b0;
    repeat (SYNC-1) @(negedge clk_i);
    mcyc_stb_i = 1'b1;
    @(negedge clk_i);
    mcyc_stb_i = 1'b0;
    check("R10_early", 1'b0);
    mcyc_stb_i = 1'b1;
    @(negedge clk_i);
    mcyc_stb_i = 1'b0;
    exp_samp = 1'b0;
    exp_eflag = 1'b1;
    check("R10_late", 1'b1);

    // R9: line glitch between strobes is ignored in level mode
    set_mode(1'b0);
    check("R9_lvl", 1'b1);
    @(negedge clk_i);
    pin_i = 1'b1;
    repeat (SYNC + 2) @(negedge clk_i);
    pin_i = 1'b0;
    check("R9_glitch", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule